// File: doc/BRIEF.md
# Split-Bus Address Tenure Master

This block is the address-phase master of a split-transaction system bus in which address and data tenures are arbitrated separately. Local logic offers one transfer at a time on a valid/ready port: an address, a 5-bit transfer type, a 4-bit size code and a burst flag. The block asks an external arbiter for the bus and waits for a grant. It starts the tenure only when no other master is showing the shared address-busy line. It then marks the start of the tenure and holds the address and attribute lines until a slave acknowledges.

The busy and start lines are shared open-drain-style wires. Each one is therefore given as a value output plus an output-enable, and the attribute lines share a single enable. After the acknowledge, busy is driven inactive for one clock and then released. A retry from the slave in the clock after the acknowledge sends the block back to arbitration with the same transfer. All bus-side control lines are active low.

Back-pressure: `req_ready` is high only while the block is idle. A transfer is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until that transfer finishes a tenure that is not retried. The request fields are only sampled on the accepting edge.

Top module: `addr_tenure_master`

## Requirements
- R1: In reset and in the first cycle after it, `bus_req_n` is 1, `req_ready` is 1, and `busy_oe`, `start_oe` and `attr_oe` are all 0.
- R2: A transfer is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle after a post-acknowledge cycle that had no retry.
- R3: `bus_req_n` is 0 from the cycle after acceptance until the tenure starts, and it is 1 throughout the tenure.
- R4: A tenure starts in the cycle after an edge at which `bus_req_n` is 0, `grant_n` is sampled 0 and `busy_n_in` is sampled 1. While `grant_n` is 1 or `busy_n_in` is 0, no tenure starts.
- R5: `start_n_out` is 0 only in the first cycle of a tenure, and `start_oe` is 1 for every cycle of the tenure.
- R6: `busy_n_out` is 0 with `busy_oe` 1 for every cycle of the tenure.
- R7: During the tenure `attr_oe` is 1, `addr_out`, `ttype_out` and `size_out` equal the accepted fields, and `burst_n_out` is the inverse of the accepted burst flag (0 means a burst of four double words). `attr_oe` is 0 outside the tenure.
- R8: An edge with `ack_n` at 0 during the tenure ends it. The next cycle has `busy_oe` 1 with `busy_n_out` 1, and `start_oe` and `attr_oe` 0. In the cycle after that, `busy_oe` is 0.
- R9: `retry_n` at 0 on the edge that ends the post-acknowledge cycle returns the block to arbitration: `bus_req_n` goes to 0 and `req_ready` stays 0. The next tenure drives the same attributes.
- R10: `retry_n` at 0 during the tenure itself has no effect. The tenure goes on with unchanged outputs and completes normally if no retry follows the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local transfer offered |
| req_ready | output | 1 | Block idle and able to take a transfer |
| req_addr | input | ADDR_W | Transfer address |
| req_ttype | input | TT_W | Transfer type code |
| req_size | input | SZ_W | Transfer size code |
| req_burst | input | 1 | 1 for a four-double-word burst |
| bus_req_n | output | 1 | Bus request to arbiter, active low |
| grant_n | input | 1 | Bus grant from arbiter, active low |
| busy_n_in | input | 1 | Observed shared address-busy line, active low |
| busy_n_out | output | 1 | Value driven on address-busy |
| busy_oe | output | 1 | Enable for the address-busy driver |
| start_n_out | output | 1 | Transfer-start value, active low |
| start_oe | output | 1 | Enable for the transfer-start driver |
| addr_out | output | ADDR_W | Address lines |
| ttype_out | output | TT_W | Transfer type lines |
| size_out | output | SZ_W | Size lines |
| burst_n_out | output | 1 | Burst line, active low |
| attr_oe | output | 1 | Enable for address, type, size and burst lines |
| ack_n | input | 1 | Address acknowledge from slave, active low |
| retry_n | input | 1 | Address retry from slave, active low |

## Verification
The hardest case is a grant that arrives while another master still holds the busy line. The block must wait through that overlap without starting. The bench plays a competing master that keeps `busy_n_in` low for a swept number of cycles, and it sweeps the grant delay independently, so grant comes before, with, or after the busy line clears. It also checks that start stays inactive in each cycle of the wait. A retry is only valid in the single cycle after the acknowledge, so the bench drives retry exactly there. It also drives a spurious retry inside the tenure, which must be ignored.

// File: rtl/att_pkg.sv
package att_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARB     = 3'd1,
    ST_START   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4
  } att_state_e;
endpackage

// File: rtl/att_req_hold.sv
module att_req_hold #(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5,
  parameter int SZ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TT_W-1:0]   in_ttype,
  input  logic [SZ_W-1:0]   in_size,
  input  logic              in_burst,
  output logic [ADDR_W-1:0] held_addr,
  output logic [TT_W-1:0]   held_ttype,
  output logic [SZ_W-1:0]   held_size,
  output logic              held_burst
);
  localparam int HOLD_W = ADDR_W + TT_W + SZ_W + 1;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (take) hold_q <= {in_addr, in_ttype, in_size, in_burst};
  end

  assign {held_addr, held_ttype, held_size, held_burst} = hold_q;
endmodule

// File: rtl/att_seq.sv
module att_seq
  import att_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       grant_n,
  input  logic       busy_n_in,
  input  logic       ack_n,
  input  logic       retry_n,
  output att_state_e state
);
  att_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (take) nxt = ST_ARB;
      ST_ARB:     if (!grant_n && busy_n_in) nxt = ST_START;
      ST_START:   nxt = ack_n ? ST_HOLD : ST_RELEASE;
      ST_HOLD:    if (!ack_n) nxt = ST_RELEASE;
      ST_RELEASE: nxt = retry_n ? ST_IDLE : ST_ARB;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= nxt;
  end
endmodule

// File: rtl/att_pins.sv
module att_pins
  import att_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5,
  parameter int SZ_W   = 4
) (
  input  att_state_e        state,
  input  logic [ADDR_W-1:0] held_addr,
  input  logic [TT_W-1:0]   held_ttype,
  input  logic [SZ_W-1:0]   held_size,
  input  logic              held_burst,
  output logic              bus_req_n,
  output logic              busy_n_out,
  output logic              busy_oe,
  output logic              start_n_out,
  output logic              start_oe,
  output logic [ADDR_W-1:0] addr_out,
  output logic [TT_W-1:0]   ttype_out,
  output logic [SZ_W-1:0]   size_out,
  output logic              burst_n_out,
  output logic              attr_oe
);
  logic in_tenure;
  assign in_tenure   = (state == ST_START) || (state == ST_HOLD);

  assign bus_req_n   = (state != ST_ARB);
  assign start_oe    = in_tenure;
  assign start_n_out = (state != ST_START);
  assign busy_oe     = in_tenure || (state == ST_RELEASE);
  assign busy_n_out  = !in_tenure;
  assign attr_oe     = in_tenure;
  assign addr_out    = held_addr;
  assign ttype_out   = held_ttype;
  assign size_out    = held_size;
  assign burst_n_out = !held_burst;
endmodule

// File: rtl/addr_tenure_master.sv
module addr_tenure_master
  import att_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5,
  parameter int SZ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TT_W-1:0]   req_ttype,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_burst,
  output logic              bus_req_n,
  input  logic              grant_n,
  input  logic              busy_n_in,
  output logic              busy_n_out,
  output logic              busy_oe,
  output logic              start_n_out,
  output logic              start_oe,
  output logic [ADDR_W-1:0] addr_out,
  output logic [TT_W-1:0]   ttype_out,
  output logic [SZ_W-1:0]   size_out,
  output logic              burst_n_out,
  output logic              attr_oe,
  input  logic              ack_n,
  input  logic              retry_n
);
  att_state_e        state;
  logic              take;
  logic [ADDR_W-1:0] h_addr;
  logic [TT_W-1:0]   h_ttype;
  logic [SZ_W-1:0]   h_size;
  logic              h_burst;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;

  att_req_hold #(.ADDR_W(ADDR_W), .TT_W(TT_W), .SZ_W(SZ_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_addr(req_addr), .in_ttype(req_ttype), .in_size(req_size), .in_burst(req_burst),
    .held_addr(h_addr), .held_ttype(h_ttype), .held_size(h_size), .held_burst(h_burst)
  );

  att_seq seq_i (
    .clk(clk), .rst_n(rst_n), .take(take), .grant_n(grant_n),
    .busy_n_in(busy_n_in), .ack_n(ack_n), .retry_n(retry_n), .state(state)
  );

  att_pins #(.ADDR_W(ADDR_W), .TT_W(TT_W), .SZ_W(SZ_W)) pins_i (
    .state(state),
    .held_addr(h_addr), .held_ttype(h_ttype), .held_size(h_size), .held_burst(h_burst),
    .bus_req_n(bus_req_n), .busy_n_out(busy_n_out), .busy_oe(busy_oe),
    .start_n_out(start_n_out), .start_oe(start_oe),
    .addr_out(addr_out), .ttype_out(ttype_out), .size_out(size_out),
    .burst_n_out(burst_n_out), .attr_oe(attr_oe)
  );
endmodule

// File: rtl/addr_tenure_master_chk.sv
module addr_tenure_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic bus_req_n,
  input logic grant_n,
  input logic busy_n_in,
  input logic busy_n_out,
  input logic busy_oe,
  input logic start_n_out,
  input logic start_oe,
  input logic attr_oe
);
  // R2
  accept_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R3
  req_off_in_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_oe |-> bus_req_n);
  // R4
  start_needs_free_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n_out && start_oe) |-> $past(!grant_n && busy_n_in && !bus_req_n));
  // R5
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n_out && start_oe) |=> start_n_out);
  // R6
  busy_held_in_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_oe |-> (busy_oe && !busy_n_out));
  // R7
  attr_with_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_oe == start_oe);
  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe && busy_n_out) |=> !busy_oe);
endmodule

bind addr_tenure_master addr_tenure_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_req_n(bus_req_n), .grant_n(grant_n), .busy_n_in(busy_n_in),
  .busy_n_out(busy_n_out), .busy_oe(busy_oe), .start_n_out(start_n_out),
  .start_oe(start_oe), .attr_oe(attr_oe)
);

// File: tb/addr_tenure_master_tb_top.sv
module addr_tenure_master_tb_top;
  localparam int ADDR_W = 32;
  localparam int TT_W   = 5;
  localparam int SZ_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [TT_W-1:0] req_ttype = '0;
  logic [SZ_W-1:0] req_size = '0;
  logic req_burst = 1'b0;
  logic bus_req_n, grant_n = 1'b1, busy_n_in = 1'b1;
  logic busy_n_out, busy_oe, start_n_out, start_oe;
  logic [ADDR_W-1:0] addr_out;
  logic [TT_W-1:0] ttype_out;
  logic [SZ_W-1:0] size_out;
  logic burst_n_out, attr_oe;
  logic ack_n = 1'b1, retry_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  addr_tenure_master #(.ADDR_W(ADDR_W), .TT_W(TT_W), .SZ_W(SZ_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ttype(req_ttype), .req_size(req_size), .req_burst(req_burst),
    .bus_req_n(bus_req_n), .grant_n(grant_n), .busy_n_in(busy_n_in),
    .busy_n_out(busy_n_out), .busy_oe(busy_oe), .start_n_out(start_n_out),
    .start_oe(start_oe), .addr_out(addr_out), .ttype_out(ttype_out),
    .size_out(size_out), .burst_n_out(burst_n_out), .attr_oe(attr_oe),
    .ack_n(ack_n), .retry_n(retry_n)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Checks every output that must hold during a tenure cycle.
  task automatic chk_tenure(input bit first, input logic [ADDR_W-1:0] a, input logic [TT_W-1:0] t,
                            input logic [SZ_W-1:0] s, input bit b);
    chk("R5", "start_oe", start_oe, 1);
    chk("R5", "start_n", start_n_out, first ? 0 : 1);
    chk("R6", "busy_oe", busy_oe, 1);
    chk("R6", "busy_n", busy_n_out, 0);
    chk("R3", "bus_req_n in tenure", bus_req_n, 1);
    chk("R7", "attr_oe", attr_oe, 1);
    chk("R7", "addr", addr_out, a);
    chk("R7", "ttype", ttype_out, t);
    chk("R7", "size", size_out, s);
    chk("R7", "burst_n", burst_n_out, !b);
  endtask

  task automatic run_tenure(input logic [ADDR_W-1:0] a, input logic [TT_W-1:0] t,
                            input logic [SZ_W-1:0] s, input bit b, input int hold, input bit retry);
    chk_tenure(1, a, t, s, b);
    for (int h = 0; h < hold; h++) begin
      retry_n = 1'b0;          // spurious retry inside tenure, R10
      step();
      retry_n = 1'b1;
      chk_tenure(0, a, t, s, b);
    end
    ack_n = 1'b0;
    step();
    ack_n = 1'b1;
    chk("R8", "busy_oe release cycle", busy_oe, 1);
    chk("R8", "busy_n release cycle", busy_n_out, 1);
    chk("R8", "start_oe off", start_oe, 0);
    chk("R8", "attr_oe off", attr_oe, 0);
    retry_n = retry ? 1'b0 : 1'b1;
    step();
    retry_n = 1'b1;
    chk("R8", "busy_oe released", busy_oe, 0);
  endtask

  task automatic xfer(input logic [ADDR_W-1:0] a, input logic [TT_W-1:0] t, input logic [SZ_W-1:0] s,
                      input bit b, input int gdly, input int bdly, input bit retry, input int hold);
    chk("R2", "ready idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_ttype = t; req_size = s; req_burst = b;
    step();
    req_valid = 1'b0; req_addr = ~a; req_ttype = ~t; req_size = ~s; req_burst = ~b;
    chk("R2", "ready after accept", req_ready, 0);
    chk("R3", "bus_req_n after accept", bus_req_n, 0);
    for (int w = 0; w < gdly || w < bdly; w++) begin
      grant_n = (w < gdly) ? 1'b1 : 1'b0;
      busy_n_in = (w < bdly) ? 1'b0 : 1'b1;
      step();
      chk("R4", "no start while blocked", start_oe, 0);
      chk("R3", "bus_req_n waiting", bus_req_n, 0);
    end
    grant_n = 1'b0; busy_n_in = 1'b1;
    step();
    grant_n = 1'b1;
    run_tenure(a, t, s, b, hold, retry);
    if (retry) begin
      chk("R9", "bus_req_n after retry", bus_req_n, 0);
      chk("R9", "ready after retry", req_ready, 0);
      grant_n = 1'b0;
      step();
      grant_n = 1'b1;
      run_tenure(a, t, s, b, 0, 1'b0);
    end
    chk("R2", "ready after completion", req_ready, 1);
    chk("R10", "idle after spurious retry", bus_req_n, 1);
  endtask

  initial begin
    #1;
    chk("R1", "ready in reset", req_ready, 1);
    chk("R1", "bus_req_n in reset", bus_req_n, 1);
    chk("R1", "oe in reset", {busy_oe, start_oe, attr_oe}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "oe after reset", {busy_oe, start_oe, attr_oe}, 0);
    // R2: grant without request must not start anything
    grant_n = 1'b0;
    step();
    grant_n = 1'b1;
    chk("R2", "no start without request", start_oe, 0);
    for (int b = 0; b < 2; b++)
      for (int g = 0; g < 3; g++)
        for (int k = 0; k < 3; k++)
          for (int r = 0; r < 2; r++) begin
            int n = ((b * 3 + g) * 3 + k) * 2 + r;
            xfer(32'h1000_0000 + n * 32'h0101_0108, TT_W'(n * 3 + 1), SZ_W'(n + 2),
                 b[0], g, k, r[0], n % 3);
          end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule